// File: doc/BRIEF.md
# Sequential Sigmoid Neuron

This block scores one 8x8 black-and-white image with a single perceptron. It holds 64 signed fixed-point weights, one bias value and a 64-pixel image in internal storage. A 256-entry activation table is held there too. Software or a loader writes all four through plain write strobes. A start pulse begins a scoring job. The controller seeds the accumulator with the bias, then visits one pixel per clock. Each lit pixel adds its weight and each dark pixel adds nothing. After the last pixel the sum is mapped into the table and the looked-up value is returned.

Arithmetic is purely fixed-point. Weights and bias are Q8.8 and the accumulator keeps 8 fraction bits. The table spans sums from -8.0 to just under +8.0 in steps of 1/16, and any sum outside that window uses the nearest end entry. A finished job raises a single-cycle completion flag. The results then hold until the next job begins.

Top module: `sigmoid_neuron`

## Requirements
- R1: After reset, busy, done, sum_out and act_out are all zero.
- R2: sum_out equals the bias plus the sum of every weight whose pixel is 1 (pixel value 1 selects, 0 skips); weights and bias are 16-bit two's complement with 8 fraction bits, sign-extended into the accumulator.
- R3: The accumulator saturates at the largest or smallest ACC_W-bit two's complement value instead of wrapping, at every step.
- R4: act_out equals table entry ((s + 2048) >> 4), where s is the final sum clamped to [-2048, 2047] raw (that is, -8.0 to +8.0 minus one LSB).
- R5: A final sum below -2048 raw returns table entry 0, and one above 2047 raw returns entry 255.
- R6: done is a one-cycle pulse, seen 65 clocks after the clock edge that samples start in the idle state; busy is high from the edge after that start until done rises.
- R7: A start pulse that arrives while a job runs is ignored: the job yields exactly one done pulse and unchanged results.
- R8: Writes to weights, bias, pixels or table while busy is high are dropped, and sum_out and act_out stay constant between jobs.
- R9: Table entries are written through lut_we/lut_addr/lut_data; entry index k holds the 8-bit output for the sum bucket k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wt_we | input | 1 | Weight write strobe |
| wt_addr | input | 6 | Weight index |
| wt_data | input | 16 | Weight value, Q8.8 |
| bias_we | input | 1 | Bias write strobe |
| bias_data | input | 16 | Bias value, Q8.8 |
| px_we | input | 1 | Pixel write strobe |
| px_addr | input | 6 | Pixel index |
| px_data | input | 1 | Pixel value |
| lut_we | input | 1 | Activation table write strobe |
| lut_addr | input | 8 | Table index |
| lut_data | input | 8 | Table value (255 means 1.0) |
| start | input | 1 | Begin a job (honoured only when idle) |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| sum_out | output | 24 | Final weighted sum, 8 fraction bits |
| act_out | output | 8 | Activated output |

## Verification
The bench builds two copies side by side. Both get the same stimulus. One copy uses the default 24-bit accumulator. The other narrows it to 18 bits.

With 64 weights of at most 16 bits, the default accumulator cannot overflow. The narrow copy therefore makes positive and negative saturation reachable with ordinary weights. The default copy covers exact sums in the table's linear range, and also both clamped ends of the table.

// File: rtl/sigmoid_neuron.sv
module sigmoid_neuron #(
  parameter int N_IN     = 64,
  parameter int W_W      = 16,
  parameter int ACC_W    = 24,
  parameter int OUT_W    = 8,
  parameter int LUT_AW   = 8,
  parameter int LUT_SPAN = 2048
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wt_we,
  input  logic [$clog2(N_IN)-1:0] wt_addr,
  input  logic [W_W-1:0]          wt_data,
  input  logic                    bias_we,
  input  logic [W_W-1:0]          bias_data,
  input  logic                    px_we,
  input  logic [$clog2(N_IN)-1:0] px_addr,
  input  logic                    px_data,
  input  logic                    lut_we,
  input  logic [LUT_AW-1:0]       lut_addr,
  input  logic [OUT_W-1:0]        lut_data,
  input  logic                    start,
  output logic                    busy,
  output logic                    done,
  output logic [ACC_W-1:0]        sum_out,
  output logic [OUT_W-1:0]        act_out
);
  localparam int IDX_W = $clog2(N_IN);
  localparam int SHIFT = $clog2(2 * LUT_SPAN) - LUT_AW;
  localparam int LUT_N = 1 << LUT_AW;
  localparam logic signed [ACC_W:0]   ACC_MAX = {2'b00, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W:0]   ACC_MIN = {2'b11, {(ACC_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] SPAN    = ACC_W'(LUT_SPAN);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_ACT} state_t;

  state_t                 state;
  logic [IDX_W-1:0]       idx;
  logic signed [ACC_W-1:0] acc;
  logic [W_W-1:0]         wmem [N_IN];
  logic [N_IN-1:0]        pmem;
  logic [OUT_W-1:0]       lmem [LUT_N];
  logic [W_W-1:0]         bias_q;

  logic signed [ACC_W:0]   wide;
  logic signed [ACC_W-1:0] acc_nx, clmp;
  logic [ACC_W-1:0]        offs;
  logic [LUT_AW-1:0]       lidx;
  logic [W_W-1:0]          wsel;

  assign busy = (state != S_IDLE);
  assign wsel = pmem[idx] ? wmem[idx] : '0;
  assign wide = {acc[ACC_W-1], acc} + {{(ACC_W+1-W_W){wsel[W_W-1]}}, wsel};
  assign acc_nx = (wide > ACC_MAX) ? ACC_MAX[ACC_W-1:0] :
                  (wide < ACC_MIN) ? ACC_MIN[ACC_W-1:0] : wide[ACC_W-1:0];
  assign clmp = (acc < -SPAN) ? -SPAN : (acc > SPAN - 1) ? SPAN - 1 : acc;
  assign offs = clmp + SPAN;
  assign lidx = LUT_AW'(offs >> SHIFT);

  always_ff @(posedge clk) begin
    if (!busy) begin
      if (wt_we)  wmem[wt_addr]  <= wt_data;
      if (lut_we) lmem[lut_addr] <= lut_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pmem   <= '0;
      bias_q <= '0;
    end else if (!busy) begin
      if (px_we)   pmem[px_addr] <= px_data;
      if (bias_we) bias_q        <= bias_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      idx     <= '0;
      acc     <= '0;
      done    <= 1'b0;
      sum_out <= '0;
      act_out <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          acc   <= {{(ACC_W-W_W){bias_q[W_W-1]}}, bias_q};
          idx   <= '0;
          state <= S_RUN;
        end
        S_RUN: begin
          acc <= acc_nx;
          idx <= idx + 1'b1;
          if (idx == IDX_W'(N_IN - 1)) state <= S_ACT;
        end
        S_ACT: begin
          sum_out <= acc;
          act_out <= lmem[lidx];
          done    <= 1'b1;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sigmoid_neuron_chk.sv
module sigmoid_neuron_chk #(
  parameter int ACC_W = 24,
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [ACC_W-1:0] sum_out,
  input logic [OUT_W-1:0] act_out
);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_start_go_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy || done));
  p_act_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(act_out));
  p_sum_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(sum_out));
endmodule

bind sigmoid_neuron sigmoid_neuron_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .sum_out(sum_out), .act_out(act_out)
);

// File: tb/sigmoid_neuron_tb.sv
`timescale 1ns/1ps
module sigmoid_neuron_tb_top;
  localparam int NARROW = 18;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wt_we = 0, bias_we = 0, px_we = 0, lut_we = 0, start = 0, px_data = 0;
  logic [5:0] wt_addr = 0, px_addr = 0;
  logic [15:0] wt_data = 0, bias_data = 0;
  logic [7:0] lut_addr = 0, lut_data = 0;
  logic busy, done, busy_n, done_n;
  logic [23:0] sum_out;
  logic [NARROW-1:0] sum_n;
  logic [7:0] act_out, act_n;

  int n_chk = 0, n_bad = 0;
  int m_w [64];
  bit m_px [64];
  int m_bias;
  int m_lut [256];

  always #4 clk = ~clk;

  sigmoid_neuron dut_i (
    .clk, .rst_n, .wt_we, .wt_addr, .wt_data, .bias_we, .bias_data,
    .px_we, .px_addr, .px_data, .lut_we, .lut_addr, .lut_data, .start,
    .busy, .done, .sum_out, .act_out);

  sigmoid_neuron #(.ACC_W(NARROW)) narrow_i (
    .clk, .rst_n, .wt_we, .wt_addr, .wt_data, .bias_we, .bias_data,
    .px_we, .px_addr, .px_data, .lut_we, .lut_addr, .lut_data, .start,
    .busy(busy_n), .done(done_n), .sum_out(sum_n), .act_out(act_n));

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_sum(int aw);
    int mx = (1 << (aw - 1)) - 1;
    int mn = -(1 << (aw - 1));
    int s = m_bias;
    for (int i = 0; i < 64; i++) begin
      if (m_px[i]) s += m_w[i];
      if (s > mx) s = mx;
      if (s < mn) s = mn;
    end
    return s;
  endfunction

  function automatic int ref_act(int s);
    int c = (s < -2048) ? -2048 : (s > 2047) ? 2047 : s;
    return m_lut[(c + 2048) >> 4];
  endfunction

  task automatic wr_wt(int a, int v);
    @(negedge clk); wt_we = 1; wt_addr = 6'(a); wt_data = 16'(v);
    @(negedge clk); wt_we = 0;
  endtask

  task automatic wr_px(int a, bit v);
    @(negedge clk); px_we = 1; px_addr = 6'(a); px_data = v;
    @(negedge clk); px_we = 0;
  endtask

  task automatic wr_bias(int v);
    @(negedge clk); bias_we = 1; bias_data = 16'(v);
    @(negedge clk); bias_we = 0;
  endtask

  task automatic load_all(int wmode, int pmode, int b);
    for (int i = 0; i < 64; i++) begin
      case (wmode)
        0: m_w[i] = ((i * 37 + 11) % 61) - 30;
        1: m_w[i] = 20000;
        default: m_w[i] = -20000;
      endcase
      wr_wt(i, m_w[i]);
      case (pmode)
        0: m_px[i] = ((i >> 3) + i) % 2 == 0;
        1: m_px[i] = 1'b0;
        default: m_px[i] = 1'b1;
      endcase
      wr_px(i, m_px[i]);
    end
    m_bias = b;
    wr_bias(b);
  endtask

  task automatic run_job(string tag, bit chk_lat);
    int cyc = 0;
    int es = ref_sum(24), en = ref_sum(NARROW);
    @(negedge clk); start = 1;
    @(posedge clk);
    @(negedge clk); start = 0;
    while (!done && cyc < 300) begin @(negedge clk); cyc++; end
    if (chk_lat) check({"R6 latency ", tag}, cyc, 65);
    check({"R2 sum ", tag}, $signed(sum_out), es);
    check({"R3 narrow sum ", tag}, $signed(sum_n), en);
    check({"R4 act ", tag}, act_out, ref_act(es));
    @(negedge clk);
    check({"R6 done one cycle ", tag}, done, 0);
  endtask

  task automatic t_reset;
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 sum", sum_out, 0);
    check("R1 act", act_out, 0);
  endtask

  task automatic t_lut;
    for (int i = 0; i < 256; i++) begin
      real x = (real'(i) - 128.0) / 16.0;
      m_lut[i] = $rtoi(255.0 / (1.0 + $exp(-x)) + 0.5);
      @(negedge clk); lut_we = 1; lut_addr = 8'(i); lut_data = 8'(m_lut[i]);
      @(negedge clk); lut_we = 0;
    end
  endtask

  task automatic t_linear;
    load_all(0, 0, 100);
    run_job("checker", 1);
    check("R9 table mid value", act_out, m_lut[(ref_sum(24) + 2048) >> 4]);
  endtask

  task automatic t_dark;
    load_all(0, 1, -77);
    run_job("dark", 1);
    check("R2 bias only", $signed(sum_out), -77);
  endtask

  task automatic t_high;
    load_all(1, 2, 0);
    run_job("high", 0);
    check("R5 top entry", act_out, m_lut[255]);
    check("R3 positive clamp", $signed(sum_n), (1 << (NARROW - 1)) - 1);
  endtask

  task automatic t_low;
    load_all(2, 2, 0);
    run_job("low", 0);
    check("R5 bottom entry", act_out, m_lut[0]);
    check("R3 negative clamp", $signed(sum_n), -(1 << (NARROW - 1)));
  endtask

  task automatic t_interfere;
    int pulses = 0;
    int es, ea, pidx;
    load_all(0, 0, 300);
    es = ref_sum(24);
    ea = ref_act(es);
    pidx = (((es < -2048) ? -2048 : (es > 2047) ? 2047 : es) + 2048) >> 4;
    @(negedge clk); start = 1;
    @(posedge clk);
    @(negedge clk); start = 0;
    repeat (5) @(negedge clk);
    start = 1;
    @(negedge clk); start = 0;
    wt_we = 1; wt_addr = 6'd0; wt_data = 16'd9000;
    px_we = 1; px_addr = 6'd1; px_data = ~m_px[1];
    bias_we = 1; bias_data = 16'd5000;
    lut_we = 1; lut_addr = 8'(pidx); lut_data = 8'(ea ^ 8'h5a);
    @(negedge clk);
    wt_we = 0; px_we = 0; bias_we = 0; lut_we = 0;
    for (int k = 0; k < 150; k++) begin
      if (done) pulses++;
      @(negedge clk);
    end
    check("R7 single done", pulses, 1);
    check("R7 sum unchanged", $signed(sum_out), es);
    repeat (20) @(negedge clk);
    check("R8 act stable", act_out, ea);
    run_job("rerun", 1);
    check("R8 writes dropped act", act_out, ea);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    t_lut;
    t_linear;
    t_dark;
    t_high;
    t_low;
    t_interfere;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule